// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Sweep Engine

This block searches for the best receive sampling delay tap of a card interface. After a start request, it sets a delay tap, asks an external checker to run one tuning-pattern exchange, and records whether that exchange passed. It does this for every tap in a fixed range. It keeps track of the longest run of neighbouring taps that passed. When the sweep ends, it programs the tap at the centre of that run and reports done.

Each tap is programmed by sending an apply strobe and then waiting for an apply-done response. Every tap is applied two times in a row, to work around a timing fault in the delay line. A missing response counts as a failed tap. Only the two high-speed bus modes that need tuning run the sweep. For any other mode, the block reports done at once and leaves the tap alone.

Top module: `tune_sweep_engine`

## Requirements
- R1: A `start_i` pulse with `mode_i` equal to 3'd4 or 3'd5 begins a sweep. With any other mode value, `done_o` pulses in the next cycle with `error_o` low, and no apply strobe or test request is issued.
- R2: A sweep applies taps 0, 1, ... up to TAP_COUNT-1 (39 by default) in ascending order. `tap_o` never exceeds TAP_COUNT-1.
- R3: Each tap is applied twice. Each application is a one-cycle `apply_stb_o` pulse followed by a wait for `apply_done_i`. `tap_o` is stable while a strobe is high. `test_req_o` pulses once, only after both applications have finished.
- R4: If `apply_done_i` does not arrive within APPLY_TIMEOUT cycles after a strobe, the tap fails. No further strobe and no test request are issued for that tap.
- R5: A passing test extends the current run by one. A failed test, or a failed application, resets the current run to zero. The best run is replaced only when the current run becomes strictly longer, so among equally long runs the earliest one wins.
- R6: The selected tap is the last tap of the best run minus half the best run length, with the half rounded down.
- R7: When at least one tap passed, the selected tap is applied twice. `done_o` then pulses with `error_o` low and `tap_o` holding the selected tap.
- R8: When no tap passed, `done_o` and `error_o` pulse together, no final application takes place, and `tap_o` stays at the last swept tap.
- R9: If the final application times out, `done_o` and `error_o` pulse together.
- R10: `done_o` is a single-cycle pulse. `error_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| mode_i | input | 3 | Bus speed mode code; 4 and 5 need tuning |
| done_o | output | 1 | Completion pulse |
| error_o | output | 1 | Failure flag, valid with done_o |
| tap_o | output | TAP_W | Delay tap presented to the delay line |
| apply_stb_o | output | 1 | Request to load tap_o into the delay line |
| apply_done_i | input | 1 | Delay line has finished loading the tap |
| test_req_o | output | 1 | Request one tuning-pattern exchange |
| test_ack_i | input | 1 | Exchange result is valid |
| test_pass_i | input | 1 | Exchange passed, sampled with test_ack_i |

## Verification
The assertions assume that `apply_done_i` rises only while an application is pending, and that `test_ack_i` comes only after a `test_req_o` and at most once for each request. They also assume that `start_i` arrives only while the engine is idle. The bench responders follow these rules: each response is scheduled only from a strobe or request seen on the ports, and each one is driven as a single-cycle pulse. A new start is issued only after the previous `done_o` has been observed. The timeout tests keep these rules by simply withholding the apply-done response.

// File: rtl/tune_pkg.sv
// Package: shared state encodings and bus mode codes for the tuning sweep.
// Assumes a 3-bit mode code supplied by the host controller.
package tune_pkg;

    localparam logic [2:0] TMODE_EMMC200 = 3'd4;
    localparam logic [2:0] TMODE_SD104   = 3'd5;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_STB,
        AP_WAIT
    } apply_state_t;

    typedef enum logic [3:0] {
        SW_IDLE,
        SW_GO,
        SW_AWAIT,
        SW_TREQ,
        SW_TWAIT,
        SW_STEP,
        SW_FGO,
        SW_FWAIT,
        SW_DONE
    } sweep_state_t;

endpackage

// File: rtl/tap_apply_unit.sv
// Module: tap_apply_unit
// Loads one delay tap by issuing REPS strobes in sequence. Each strobe waits up
// to TIMEOUT cycles for the done response. A timeout ends the sequence with
// ok_o low. fin_o pulses for one cycle when the sequence ends; ok_o is valid
// in that cycle.
// Assumes go_i is raised only while the unit is idle.
module tap_apply_unit
    import tune_pkg::*;
#(
    parameter int TIMEOUT = 8,
    parameter int REPS    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic apply_done_i,
    output logic stb_o,
    output logic busy_o,
    output logic fin_o,
    output logic ok_o
);

    localparam int TW = $clog2(TIMEOUT + 1);
    localparam int RW = $clog2(REPS + 1);

    apply_state_t  st_q;
    logic [TW-1:0] timer_q;
    logic [RW-1:0] rep_q;
    logic          last_rep;
    logic          expired;

    // Decode whether this is the final repetition and whether the wait has run out.
    always_comb begin
        last_rep = (rep_q == RW'(REPS - 1));
        expired  = (timer_q == TW'(TIMEOUT - 1));
    end

    // Sequence strobe, wait and repeat; count cycles spent waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= AP_IDLE;
            timer_q <= '0;
            rep_q   <= '0;
        end else begin
            case (st_q)
                AP_IDLE: begin
                    if (go_i) begin
                        st_q  <= AP_STB;
                        rep_q <= '0;
                    end
                end
                AP_STB: begin
                    st_q    <= AP_WAIT;
                    timer_q <= '0;
                end
                AP_WAIT: begin
                    if (apply_done_i) begin
                        if (last_rep) begin
                            st_q <= AP_IDLE;
                        end else begin
                            rep_q <= rep_q + 1'b1;
                            st_q  <= AP_STB;
                        end
                    end else if (expired) begin
                        st_q <= AP_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: st_q <= AP_IDLE;
            endcase
        end
    end

    // Drive the strobe, busy and completion outputs from the state.
    always_comb begin
        stb_o  = (st_q == AP_STB);
        busy_o = (st_q != AP_IDLE);
        fin_o  = (st_q == AP_WAIT) && ((apply_done_i && last_rep) || (!apply_done_i && expired));
        ok_o   = (st_q == AP_WAIT) && apply_done_i && last_rep;
    end

    // R3: a strobe lasts exactly one cycle
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);

    // R4: the wait counter never passes the timeout bound
    p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q < TW'(TIMEOUT));

    // R4: after completion the unit is idle again
    p_fin_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o);

    // R3: a new sequence starts only from idle
    p_go_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);

endmodule

// File: rtl/streak_tracker.sv
// Module: streak_tracker
// Keeps the current run of passing taps, the longest run so far and the tap on
// which that longest run ended. pick_o is the centre tap of the longest run.
// Assumes taps are recorded in ascending order and clear_i comes before a sweep.
module streak_tracker #(
    parameter int TAP_W     = 6,
    parameter int TAP_COUNT = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             rec_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [TAP_W-1:0] pick_o,
    output logic             found_o
);

    localparam int SW = $clog2(TAP_COUNT + 1);

    logic [SW-1:0]    cur_q;
    logic [SW-1:0]    best_q;
    logic [TAP_W-1:0] end_q;
    logic [SW-1:0]    cur_next;

    // Length the current run would reach if this tap passes.
    always_comb cur_next = cur_q + 1'b1;

    // Update the current and best runs on each recorded tap result.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cur_q  <= '0;
            best_q <= '0;
            end_q  <= '0;
        end else if (rec_i) begin
            if (pass_i) begin
                cur_q <= cur_next;
                if (cur_next > best_q) begin
                    best_q <= cur_next;
                    end_q  <= tap_i;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

    // Centre of the best run: end tap minus half its length, rounded down.
    always_comb begin
        pick_o  = end_q - TAP_W'(best_q >> 1);
        found_o = (best_q != '0);
    end

    // R5: the best run only grows between clears
    p_best_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> best_q >= $past(best_q));

    // R5: the current run never exceeds the best run
    p_cur_le_best_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= best_q);

    // R6: the selected tap lies at or before the end of the best run
    p_pick_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> pick_o <= end_q);

endmodule

// File: rtl/tune_sweep_engine.sv
// Module: tune_sweep_engine (top)
// Sweeps the receive sampling delay over taps 0..TAP_COUNT-1. Each tap is
// applied twice, then one external pass/fail test runs. When the sweep ends,
// the centre tap of the longest passing run is applied, and done pulses.
// Assumes start_i arrives only while idle, and that each test_ack_i answers
// one test_req_o.
module tune_sweep_engine
    import tune_pkg::*;
#(
    parameter int TAP_W         = 6,
    parameter int TAP_COUNT     = 40,
    parameter int APPLY_TIMEOUT = 8,
    parameter int APPLY_REPS    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       mode_i,
    output logic             done_o,
    output logic             error_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             apply_stb_o,
    input  logic             apply_done_i,
    output logic             test_req_o,
    input  logic             test_ack_i,
    input  logic             test_pass_i
);

    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAP_COUNT - 1);

    sweep_state_t     st_q;
    logic [TAP_W-1:0] tap_q;
    logic             err_q;
    logic             tune_mode;
    logic             ap_go, ap_busy, ap_fin, ap_ok;
    logic             rec, rec_pass, clear;
    logic [TAP_W-1:0] pick;
    logic             found;

    // Decode the modes that need a sweep and the control pulses to the sub-units.
    always_comb begin
        tune_mode = (mode_i == TMODE_EMMC200) || (mode_i == TMODE_SD104);
        ap_go     = (st_q == SW_GO) || (st_q == SW_FGO);
        clear     = (st_q == SW_IDLE) && start_i && tune_mode;
        rec       = ((st_q == SW_AWAIT) && ap_fin && !ap_ok) ||
                    ((st_q == SW_TWAIT) && test_ack_i);
        rec_pass  = (st_q == SW_TWAIT) && test_pass_i;
    end

    tap_apply_unit #(
        .TIMEOUT (APPLY_TIMEOUT),
        .REPS    (APPLY_REPS)
    ) u_apply (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (ap_go),
        .apply_done_i (apply_done_i),
        .stb_o        (apply_stb_o),
        .busy_o       (ap_busy),
        .fin_o        (ap_fin),
        .ok_o         (ap_ok)
    );

    streak_tracker #(
        .TAP_W     (TAP_W),
        .TAP_COUNT (TAP_COUNT)
    ) u_streak (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .rec_i   (rec),
        .pass_i  (rec_pass),
        .tap_i   (tap_q),
        .pick_o  (pick),
        .found_o (found)
    );

    // Sweep sequencer: apply, test, step, then final apply or error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SW_IDLE;
            tap_q <= '0;
            err_q <= 1'b0;
        end else begin
            case (st_q)
                SW_IDLE: begin
                    if (start_i) begin
                        err_q <= 1'b0;
                        if (tune_mode) begin
                            tap_q <= '0;
                            st_q  <= SW_GO;
                        end else begin
                            st_q <= SW_DONE;
                        end
                    end
                end
                SW_GO:    st_q <= SW_AWAIT;
                SW_AWAIT: begin
                    if (ap_fin) st_q <= ap_ok ? SW_TREQ : SW_STEP;
                end
                SW_TREQ:  st_q <= SW_TWAIT;
                SW_TWAIT: begin
                    if (test_ack_i) st_q <= SW_STEP;
                end
                SW_STEP: begin
                    if (tap_q == LAST_TAP) begin
                        if (found) begin
                            tap_q <= pick;
                            st_q  <= SW_FGO;
                        end else begin
                            err_q <= 1'b1;
                            st_q  <= SW_DONE;
                        end
                    end else begin
                        tap_q <= tap_q + 1'b1;
                        st_q  <= SW_GO;
                    end
                end
                SW_FGO:   st_q <= SW_FWAIT;
                SW_FWAIT: begin
                    if (ap_fin) begin
                        err_q <= !ap_ok;
                        st_q  <= SW_DONE;
                    end
                end
                SW_DONE:  st_q <= SW_IDLE;
                default:  st_q <= SW_IDLE;
            endcase
        end
    end

    // Drive the handshake and tap outputs.
    always_comb begin
        tap_o      = tap_q;
        test_req_o = (st_q == SW_TREQ);
        done_o     = (st_q == SW_DONE);
        error_o    = (st_q == SW_DONE) && err_q;
    end

    // R10: error only together with done
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the tap stays inside the swept range
    p_tap_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q <= LAST_TAP);

    // R3: the tap is steady while a strobe is presented
    p_tap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb_o |-> $stable(tap_o));

    // R3: a test is requested only once tap application has finished
    p_test_after_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        test_req_o |-> !ap_busy);

    // R8: with no passing tap the sweep ends without a final application
    p_no_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SW_STEP && tap_q == LAST_TAP && !found) |=> (done_o && error_o));

endmodule

// File: tb/tune_sweep_engine_tb.sv
module tune_sweep_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [2:0] mode_i;
    logic       done_o, error_o;
    logic [5:0] tap_o;
    logic       apply_stb_o, apply_done_i;
    logic       test_req_o, test_ack_i, test_pass_i;

    int n_chk = 0;
    int n_bad = 0;

    // responder configuration and observations
    logic [63:0] pass_mask = '0;
    logic [63:0] dead_mask = '0;
    int ack_limit  = 1000000;
    int ap_lat     = 2;
    int t_lat      = 3;
    int strobe_cnt = 0;
    int test_cnt   = 0;
    int max_tap    = 0;
    int ap_pend    = 0;
    int tq_pend    = 0;
    logic [5:0] tq_tap = '0;

    // results of the last run
    int   r_cycles;
    logic r_err;
    logic [5:0] r_tap;

    always #4 clk = ~clk;

    tune_sweep_engine u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
        .done_o (done_o), .error_o (error_o), .tap_o (tap_o),
        .apply_stb_o (apply_stb_o), .apply_done_i (apply_done_i),
        .test_req_o (test_req_o), .test_ack_i (test_ack_i), .test_pass_i (test_pass_i)
    );

    // Delay line and pattern checker model, driven at the falling edge.
    initial begin
        apply_done_i = 1'b0;
        test_ack_i   = 1'b0;
        test_pass_i  = 1'b0;
        forever begin
            @(negedge clk);
            apply_done_i = 1'b0;
            test_ack_i   = 1'b0;
            test_pass_i  = 1'b0;
            if (ap_pend > 0) begin
                ap_pend--;
                if (ap_pend == 0) apply_done_i = 1'b1;
            end
            if (tq_pend > 0) begin
                tq_pend--;
                if (tq_pend == 0) begin
                    test_ack_i  = 1'b1;
                    test_pass_i = pass_mask[tq_tap];
                end
            end
            if (apply_stb_o) begin
                strobe_cnt++;
                if (int'(tap_o) > max_tap) max_tap = int'(tap_o);
                if (!dead_mask[tap_o] && strobe_cnt <= ack_limit) ap_pend = ap_lat;
            end
            if (test_req_o) begin
                test_cnt++;
                tq_pend = t_lat;
                tq_tap  = tap_o;
            end
        end
    end

    function automatic logic [63:0] span(input int lo, input int hi);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Start one run and wait for done; a missing done counts as a failed check.
    task automatic run_sweep(input logic [2:0] mode);
        strobe_cnt = 0;
        test_cnt   = 0;
        max_tap    = 0;
        @(negedge clk);
        mode_i  = mode;
        start_i = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        r_cycles = 1;
        while (!done_o && r_cycles < 5000) begin
            @(negedge clk);
            r_cycles++;
        end
        r_err = error_o;
        r_tap = tap_o;
        if (!done_o) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual no done expected done");
        end
        @(negedge clk);
        check("R10", "done single pulse", int'(done_o), 0);
    endtask

    task automatic t_reset;
        check("R10", "reset done", int'(done_o), 0);
        check("R10", "reset error", int'(error_o), 0);
        check("R2", "reset tap", int'(tap_o), 0);
        check("R3", "reset strobe", int'(apply_stb_o), 0);
        check("R3", "reset test", int'(test_req_o), 0);
    endtask

    task automatic t_skip_mode;
        pass_mask = '1;
        run_sweep(3'd0);
        check("R1", "skip latency", r_cycles, 1);
        check("R1", "skip error", int'(r_err), 0);
        check("R1", "skip strobes", strobe_cnt, 0);
        check("R1", "skip tests", test_cnt, 0);
        run_sweep(3'd6);
        check("R1", "mode6 strobes", strobe_cnt, 0);
    endtask

    task automatic t_single_run;
        pass_mask = span(10, 19);
        run_sweep(3'd4);
        check("R6", "centre tap", int'(r_tap), 14);
        check("R7", "no error", int'(r_err), 0);
        check("R3", "double apply strobes", strobe_cnt, 82);
        check("R3", "one test per tap", test_cnt, 40);
        check("R2", "max tap", max_tap, 39);
    endtask

    task automatic t_tie_runs;
        pass_mask = span(2, 5) | span(20, 25) | span(30, 35);
        run_sweep(3'd4);
        check("R5", "earliest longest run wins", int'(r_tap), 22);
        check("R7", "tie error", int'(r_err), 0);
    endtask

    task automatic t_odd_end;
        pass_mask = span(33, 39);
        run_sweep(3'd5);
        check("R6", "odd length at range end", int'(r_tap), 36);
        check("R2", "max tap odd", max_tap, 39);
    endtask

    task automatic t_all_fail;
        pass_mask = '0;
        run_sweep(3'd4);
        check("R8", "error raised", int'(r_err), 1);
        check("R8", "tap left at last", int'(r_tap), 39);
        check("R8", "no final apply", strobe_cnt, 80);
    endtask

    task automatic t_apply_timeout;
        pass_mask = span(10, 19);
        dead_mask = '0;
        dead_mask[12] = 1'b1;
        run_sweep(3'd4);
        dead_mask = '0;
        check("R4", "timeout splits run", int'(r_tap), 16);
        check("R4", "single strobe on dead tap", strobe_cnt, 81);
        check("R4", "no test on dead tap", test_cnt, 39);
    endtask

    task automatic t_first_only;
        pass_mask = span(0, 0);
        run_sweep(3'd5);
        check("R6", "single passing tap 0", int'(r_tap), 0);
        check("R7", "final double apply", strobe_cnt, 82);
    endtask

    task automatic t_all_pass;
        pass_mask = '1;
        run_sweep(3'd4);
        check("R6", "full range centre", int'(r_tap), 19);
        check("R7", "full range error", int'(r_err), 0);
    endtask

    task automatic t_final_timeout;
        pass_mask = span(10, 19);
        ack_limit = 80;
        run_sweep(3'd4);
        ack_limit = 1000000;
        check("R9", "final timeout error", int'(r_err), 1);
        check("R9", "final tap presented", int'(r_tap), 14);
        check("R9", "one final strobe", strobe_cnt, 81);
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 global watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        start_i = 1'b0;
        mode_i  = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_skip_mode();
        t_single_run();
        t_tie_runs();
        t_odd_end();
        t_all_fail();
        t_apply_timeout();
        t_first_only();
        t_all_pass();
        t_final_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule